// File: doc/BRIEF.md
# Single-Wire Pulse-Width Control Bus Slave

This block is the device end of a shared, open-drain control line that idles high and is pulled low by whoever talks. Symbols are not clocked: each one is the length of a single low pulse. The slave times every low pulse on the system clock and sorts it into one of three widths: a short pulse (logic 0, which is also what the host sends as a read prompt), a medium pulse (logic 1), and a long delimiter pulse that opens a new frame. Every other width is a line fault.

A frame begins with a delimiter. It then carries a broadcast flag, a 4-bit device address sent least-significant bit first, and an operation bit. A write then carries eight data bits, most-significant bit first. The slave stores them in an 8-bit control register, whose fields drive the analogue video path around it. A read instead carries eight short prompts from the host. After each prompt the slave answers with one register bit, pulling the line low for a 0 and leaving it high for a 1, in a fixed window after the prompt ends. The slave never drives the line high. It only asserts a pull-low enable. The line comes in through a two-flop synchroniser, and all time limits scale from a clock-cycles-per-microsecond parameter.

Top module: `pwb_slave`

## Requirements
- R1: After reset the control register reads 0x60. The register bit positions drive these outputs: bit 7 `sync_in_o` (sync pin as input), bit 6 `sel_a_o` (input A selected), bit 5 `filt_en_o` (1 = filter active, 0 = bypass), bit 4 `clamp_hi_o`, bits 3:2 `boost_o`, bit 1 `out_hiz_o` (1 = output high impedance) and bit 0 `spare_o`.
- R2: A low pulse lasting from 1.5 µs up to 8 µs, both ends included, decodes as logic 0. A shorter pulse is a fault.
- R3: A low pulse lasting from 24 µs to 36 µs, both ends included, decodes as logic 1.
- R4: A low pulse lasting from 80 µs to 120 µs, both ends included, is a delimiter and starts a new frame.
- R5: A write frame is: a delimiter, a broadcast flag (1 = broadcast), address bits A0..A3, an operation bit of 0, then data bits D7..D0. The register takes the data when the eighth data pulse ends.
- R6: When the broadcast flag is 0 and the address differs from `my_addr_i`, the frame leaves the register unchanged and the slave never pulls the line.
- R7: When the broadcast flag is 1, a write is applied whatever the address field holds.
- R8: A pulse outside every accepted band, for example 15 µs or 50 µs long, aborts the frame and leaves the register unchanged. All later pulses are ignored until the next delimiter.
- R9: In a read frame (operation bit 1, address matched, not broadcast), each prompt returns one register bit, MSB first. For a 0 bit the slave pulls the line low from 1 µs to 6 µs after the prompt ends. For a 1 bit, and outside read windows, it never pulls.
- R10: For 8 µs after each prompt the receiver ignores the line, so the slave's own pull is never decoded as a symbol.
- R11: A delimiter that arrives in the middle of a frame discards the partial frame and starts a new one.
- R12: Data or prompt pulses that follow a completed write or read are ignored until the next delimiter.
- R13: A read frame with the broadcast flag set is ignored: no bit is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_i | input | 1 | Bus line as seen at the pin, asynchronous |
| my_addr_i | input | 4 | This device's address |
| pull_low_o | output | 1 | Enables the open-drain pull-down on the line |
| sync_in_o | output | 1 | Register bit 7: sync pin direction |
| sel_a_o | output | 1 | Register bit 6: input A select |
| filt_en_o | output | 1 | Register bit 5: filter active |
| clamp_hi_o | output | 1 | Register bit 4: clamp level |
| boost_o | output | 2 | Register bits 3:2: high-frequency boost |
| out_hiz_o | output | 1 | Register bit 1: output disable |
| spare_o | output | 1 | Register bit 0: unused field |

## Verification
The bench probes every band edge one cycle inside and one cycle outside. A classifier with an off-by-one compare would then accept a fault or drop a valid bit, and that shows as a register that changes or fails to change. Reads are checked in the middle of the drive window and after it ends. A slave that does not blank its receiver would decode its own 5 µs pull as an extra prompt and return shifted bits. The bench also sends address mismatches, broadcast reads, aborts in the gap bands, restarts in mid-frame and trailing pulses after a finished write. A design that kept partial state or committed early would alter the register, and the bench compares the register on every clock.

// File: rtl/pwb_pkg.sv
package pwb_pkg;

    localparam int unsigned CTRL_W   = 8;
    localparam int unsigned ADDR_W   = 4;
    localparam int unsigned HDR_BITS = 6;   // flag, four address bits, op

    localparam logic [CTRL_W-1:0] CTRL_RESET = 8'h60;

    typedef enum logic [1:0] {
        PW_ZERO,
        PW_ONE,
        PW_TXN,
        PW_BAD
    } pw_cls_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_DATA,
        ST_READ,
        ST_SLOT
    } fsm_e;

endpackage

// File: rtl/pwb_sync.sv
module pwb_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [1:0] stage_q;
    logic [1:0] stage_d;

    always_comb begin
        stage_d = {stage_q[0], async_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= 2'b11;   // idle line is high
        else        stage_q <= stage_d;
    end

    assign sync_o = stage_q[1];
endmodule

// File: rtl/pwb_meter.sv
module pwb_meter
    import pwb_pkg::*;
#(
    parameter int unsigned Z_MIN = 6,
    parameter int unsigned Z_MAX = 32,
    parameter int unsigned O_MIN = 96,
    parameter int unsigned O_MAX = 144,
    parameter int unsigned T_MIN = 320,
    parameter int unsigned T_MAX = 480
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    line_s,
    input  logic    blank_i,
    output logic    done_o,
    output pw_cls_e cls_o
);
    localparam int unsigned CNT_W = $clog2(T_MAX + 2);
    localparam logic [CNT_W-1:0] SAT_C   = CNT_W'(T_MAX + 1);
    localparam logic [CNT_W-1:0] Z_MIN_C = CNT_W'(Z_MIN);
    localparam logic [CNT_W-1:0] Z_MAX_C = CNT_W'(Z_MAX);
    localparam logic [CNT_W-1:0] O_MIN_C = CNT_W'(O_MIN);
    localparam logic [CNT_W-1:0] O_MAX_C = CNT_W'(O_MAX);
    localparam logic [CNT_W-1:0] T_MIN_C = CNT_W'(T_MIN);
    localparam logic [CNT_W-1:0] T_MAX_C = CNT_W'(T_MAX);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             done;
        pw_cls_e          cls;
    } meter_t;

    meter_t m_q, m_d;

    function automatic pw_cls_e classify(input logic [CNT_W-1:0] n);
        if (n >= Z_MIN_C && n <= Z_MAX_C)      return PW_ZERO;
        else if (n >= O_MIN_C && n <= O_MAX_C) return PW_ONE;
        else if (n >= T_MIN_C && n <= T_MAX_C) return PW_TXN;
        else                                   return PW_BAD;
    endfunction

    always_comb begin
        m_d      = m_q;
        m_d.done = 1'b0;
        if (blank_i) begin
            m_d.cnt = '0;
        end else if (!line_s) begin
            if (m_q.cnt != SAT_C) m_d.cnt = m_q.cnt + 1'b1;
        end else if (m_q.cnt != '0) begin
            m_d.done = 1'b1;
            m_d.cls  = classify(m_q.cnt);
            m_d.cnt  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) m_q <= '{cnt: '0, done: 1'b0, cls: PW_BAD};
        else        m_q <= m_d;
    end

    assign done_o = m_q.done;
    assign cls_o  = m_q.cls;
endmodule

// File: rtl/pwb_frame.sv
module pwb_frame
    import pwb_pkg::*;
#(
    parameter int unsigned DRV_ON   = 4,
    parameter int unsigned DRV_OFF  = 24,
    parameter int unsigned SLOT_LEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done_i,
    input  pw_cls_e           cls_i,
    input  logic [ADDR_W-1:0] my_addr_i,
    output logic [CTRL_W-1:0] ctrl_o,
    output logic              pull_low_o,
    output logic              blank_o
);
    localparam int unsigned TMR_W = $clog2(SLOT_LEN + 1);
    localparam logic [TMR_W-1:0] ON_C   = TMR_W'(DRV_ON);
    localparam logic [TMR_W-1:0] OFF_C  = TMR_W'(DRV_OFF);
    localparam logic [TMR_W-1:0] LAST_C = TMR_W'(SLOT_LEN - 1);
    localparam logic [2:0]       HDR_LAST = 3'(HDR_BITS - 1);

    typedef struct packed {
        fsm_e                st;
        logic [2:0]          bcnt;
        logic [HDR_BITS-1:0] hdr;
        logic [CTRL_W-1:0]   shr;
        logic [CTRL_W-1:0]   ctrl;
        logic [TMR_W-1:0]    tmr;
    } frame_t;

    frame_t f_q, f_d;
    logic   rx_bit;
    logic   hit;
    logic [2:0] rd_idx;

    always_comb begin
        f_d    = f_q;
        rx_bit = (cls_i == PW_ONE);
        hit    = f_q.hdr[0] | (f_q.hdr[4:1] == my_addr_i);
        if (f_q.st == ST_SLOT) begin
            f_d.tmr = f_q.tmr + 1'b1;
            if (f_q.tmr == LAST_C) begin
                f_d.tmr = '0;
                if (f_q.bcnt == 3'd7) begin
                    f_d.st   = ST_IDLE;
                    f_d.bcnt = '0;
                end else begin
                    f_d.st   = ST_READ;
                    f_d.bcnt = f_q.bcnt + 1'b1;
                end
            end
        end else if (done_i) begin
            if (cls_i == PW_TXN) begin
                f_d.st   = ST_HDR;
                f_d.bcnt = '0;
                f_d.hdr  = '0;
            end else if (cls_i == PW_BAD) begin
                f_d.st = ST_IDLE;
            end else begin
                case (f_q.st)
                    ST_HDR: begin
                        f_d.hdr[f_q.bcnt] = rx_bit;
                        f_d.bcnt          = f_q.bcnt + 1'b1;
                        if (f_q.bcnt == HDR_LAST) begin
                            f_d.bcnt = '0;
                            if (!hit)            f_d.st = ST_IDLE;
                            else if (!rx_bit)    f_d.st = ST_DATA;
                            else if (f_q.hdr[0]) f_d.st = ST_IDLE;
                            else                 f_d.st = ST_READ;
                        end
                    end
                    ST_DATA: begin
                        f_d.shr  = {f_q.shr[CTRL_W-2:0], rx_bit};
                        f_d.bcnt = f_q.bcnt + 1'b1;
                        if (f_q.bcnt == 3'd7) begin
                            f_d.ctrl = {f_q.shr[CTRL_W-2:0], rx_bit};
                            f_d.st   = ST_IDLE;
                            f_d.bcnt = '0;
                        end
                    end
                    ST_READ: begin
                        if (rx_bit) begin
                            f_d.st = ST_IDLE;
                        end else begin
                            f_d.st  = ST_SLOT;
                            f_d.tmr = '0;
                        end
                    end
                    default: f_d.st = ST_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '{st: ST_IDLE, bcnt: '0, hdr: '0, shr: '0,
                             ctrl: CTRL_RESET, tmr: '0};
        else        f_q <= f_d;
    end

    assign rd_idx     = 3'd7 - f_q.bcnt;
    assign pull_low_o = (f_q.st == ST_SLOT) && (f_q.tmr >= ON_C) &&
                        (f_q.tmr < OFF_C) && !f_q.ctrl[rd_idx];
    assign blank_o    = (f_q.st == ST_SLOT);
    assign ctrl_o     = f_q.ctrl;
endmodule

// File: rtl/pwb_slave.sv
module pwb_slave
    import pwb_pkg::*;
#(
    parameter int unsigned CYC_PER_US = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       line_i,
    input  logic [3:0] my_addr_i,
    output logic       pull_low_o,
    output logic       sync_in_o,
    output logic       sel_a_o,
    output logic       filt_en_o,
    output logic       clamp_hi_o,
    output logic [1:0] boost_o,
    output logic       out_hiz_o,
    output logic       spare_o
);
    localparam int unsigned Z_MIN    = (15 * CYC_PER_US + 9) / 10;
    localparam int unsigned Z_MAX    = 8 * CYC_PER_US;
    localparam int unsigned O_MIN    = 24 * CYC_PER_US;
    localparam int unsigned O_MAX    = 36 * CYC_PER_US;
    localparam int unsigned T_MIN    = 80 * CYC_PER_US;
    localparam int unsigned T_MAX    = 120 * CYC_PER_US;
    localparam int unsigned DRV_ON   = 1 * CYC_PER_US;
    localparam int unsigned DRV_OFF  = 6 * CYC_PER_US;
    localparam int unsigned SLOT_LEN = 8 * CYC_PER_US;

    logic              line_s;
    logic              blank;
    logic              pulse_done;
    pw_cls_e           pulse_cls;
    logic [CTRL_W-1:0] ctrl_w;

    pwb_sync sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (line_i),
        .sync_o  (line_s)
    );

    pwb_meter #(
        .Z_MIN (Z_MIN), .Z_MAX (Z_MAX),
        .O_MIN (O_MIN), .O_MAX (O_MAX),
        .T_MIN (T_MIN), .T_MAX (T_MAX)
    ) meter_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_s  (line_s),
        .blank_i (blank),
        .done_o  (pulse_done),
        .cls_o   (pulse_cls)
    );

    pwb_frame #(
        .DRV_ON   (DRV_ON),
        .DRV_OFF  (DRV_OFF),
        .SLOT_LEN (SLOT_LEN)
    ) frame_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .done_i     (pulse_done),
        .cls_i      (pulse_cls),
        .my_addr_i  (my_addr_i),
        .ctrl_o     (ctrl_w),
        .pull_low_o (pull_low_o),
        .blank_o    (blank)
    );

    assign sync_in_o  = ctrl_w[7];
    assign sel_a_o    = ctrl_w[6];
    assign filt_en_o  = ctrl_w[5];
    assign clamp_hi_o = ctrl_w[4];
    assign boost_o    = ctrl_w[3:2];
    assign out_hiz_o  = ctrl_w[1];
    assign spare_o    = ctrl_w[0];
endmodule

// File: rtl/pwb_slave_chk.sv
module pwb_slave_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       pull_low,
    input logic       pulse_done,
    input logic [7:0] ctrl
);
    // R1: reset loads the default register image
    assert_reset_image_R1: assert property (@(posedge clk)
        !rst_n |=> (ctrl == 8'h60));

    // R5: the register moves only in the cycle after a decoded pulse
    assert_reg_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !pulse_done |=> $stable(ctrl));

    // R10: nothing is decoded while the slave drives the line
    assert_no_decode_driving_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pull_low |-> !pulse_done);

    // R10: blanking still holds in the cycle after a driven cycle
    assert_blank_after_drive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pull_low |=> !pulse_done);

    // R2: each low pulse yields exactly one decode strobe
    assert_single_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_done |=> !pulse_done);
endmodule

bind pwb_slave pwb_slave_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .pull_low   (pull_low_o),
    .pulse_done (pulse_done),
    .ctrl       (ctrl_w)
);

// File: tb/pwb_slave_tb.sv
module pwb_slave_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int CPU        = 4;
    localparam int ZERO_W     = 5 * CPU;
    localparam int ONE_W      = 30 * CPU;
    localparam int TXN_W      = 100 * CPU;
    localparam logic [3:0] MY_ADDR = 4'hA;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_low = 1'b0;
    logic       line_w;
    logic       pull_low;
    logic       sync_in, sel_a, filt_en, clamp_hi, out_hiz, spare;
    logic [1:0] boost;

    int   checks = 0;
    int   errors = 0;
    bit   finished = 1'b0;
    bit   in_read = 1'b0;
    logic [7:0] model = 8'h60;
    bit   pend_v = 1'b0;
    logic [7:0] pend_val = 8'h00;

    always #(CLK_PERIOD / 2) clk = ~clk;

    assign line_w = ~(host_low | pull_low);

    pwb_slave #(.CYC_PER_US(CPU)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_i     (line_w),
        .my_addr_i  (MY_ADDR),
        .pull_low_o (pull_low),
        .sync_in_o  (sync_in),
        .sel_a_o    (sel_a),
        .filt_en_o  (filt_en),
        .clamp_hi_o (clamp_hi),
        .boost_o    (boost),
        .out_hiz_o  (out_hiz),
        .spare_o    (spare)
    );

    function automatic logic [7:0] fields();
        return {sync_in, sel_a, filt_en, clamp_hi, boost, out_hiz, spare};
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    // every-clock comparison against the behavioural register model
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check(fields() == model, "R1 register fields vs model", fields(), model);
            if (!in_read) check(pull_low == 1'b0, "R9 no pull outside read", pull_low, 0);
        end
    end

    // one low pulse; model takes a pending value 4 edges after release
    task automatic pulse(input int len);
        @(negedge clk) host_low = 1'b1;
        repeat (len) @(negedge clk);
        host_low = 1'b0;
        repeat (4) @(posedge clk);
        #1;
        if (pend_v) begin
            model  = pend_val;
            pend_v = 1'b0;
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic send_hdr(input bit bc, input logic [3:0] addr, input bit op);
        pulse(TXN_W);
        pulse(bc ? ONE_W : ZERO_W);
        for (int i = 0; i < 4; i++) pulse(addr[i] ? ONE_W : ZERO_W);
        pulse(op ? ONE_W : ZERO_W);
    endtask

    task automatic write_w(input bit bc, input logic [3:0] addr, input logic [7:0] data,
                           input int zw, input int ow, input int tw, input bit applies);
        pulse(tw);
        pulse(bc ? ONE_W : ZERO_W);
        for (int i = 0; i < 4; i++) pulse(addr[i] ? ONE_W : ZERO_W);
        pulse(ZERO_W);
        for (int i = 7; i >= 0; i--) begin
            if (i == 0 && applies) begin
                pend_v   = 1'b1;
                pend_val = data;
            end
            pulse(data[i] ? ow : zw);
        end
    endtask

    task automatic write_frame(input bit bc, input logic [3:0] addr, input logic [7:0] data);
        write_w(bc, addr, data, ZERO_W, ONE_W, TXN_W, bc || (addr == MY_ADDR));
    endtask

    task automatic read_frame(input bit bc, input logic [3:0] addr, input string tag);
        bit drives;
        drives = !bc && (addr == MY_ADDR);
        send_hdr(bc, addr, 1'b1);
        in_read = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            @(negedge clk) host_low = 1'b1;
            repeat (ZERO_W) @(negedge clk);
            host_low = 1'b0;
            repeat (18) @(posedge clk);
            #1;
            check(pull_low == (drives && !model[i]), tag, pull_low, drives && !model[i]);
            repeat (12) @(posedge clk);
            #1;
            check(pull_low == 1'b0, "R9 pull released after window", pull_low, 0);
            repeat (20) @(negedge clk);
        end
        in_read = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(fields() == 8'h60, "R1 reset value", fields(), 8'h60);

        // R5: plain matched write
        write_frame(1'b0, MY_ADDR, 8'hA5);
        check(fields() == 8'hA5, "R5 matched write", fields(), 8'hA5);

        // R6: other address, no broadcast
        write_frame(1'b0, 4'h5, 8'h3C);
        check(fields() == 8'hA5, "R6 mismatch ignored", fields(), 8'hA5);

        // R7: broadcast with a foreign address field
        write_frame(1'b1, 4'h3, 8'h9B);
        check(fields() == 8'h9B, "R7 broadcast write", fields(), 8'h9B);

        // R9 R10: matched read returns the register MSB first
        read_frame(1'b0, MY_ADDR, "R9 R10 readback bit");
        // R6: mismatched read drives nothing
        read_frame(1'b0, 4'h2, "R6 no drive on mismatch");
        // R13: broadcast read drives nothing
        read_frame(1'b1, MY_ADDR, "R13 broadcast read silent");

        // R8: abort in the 8..24 us gap
        send_hdr(1'b0, MY_ADDR, 1'b0);
        for (int i = 0; i < 4; i++) pulse(ZERO_W);
        pulse(15 * CPU);
        for (int i = 0; i < 8; i++) pulse(ONE_W);
        check(fields() == 8'h9B, "R8 abort 15us", fields(), 8'h9B);
        // R8: abort in the 36..80 us gap
        send_hdr(1'b0, MY_ADDR, 1'b0);
        pulse(50 * CPU);
        for (int i = 0; i < 8; i++) pulse(ZERO_W);
        check(fields() == 8'h9B, "R8 abort 50us", fields(), 8'h9B);

        // R2 R3 R4: band edges accepted
        write_w(1'b0, MY_ADDR, 8'h5A, 6, 96, 320, 1'b1);
        check(fields() == 8'h5A, "R2 R3 R4 low edges", fields(), 8'h5A);
        write_w(1'b0, MY_ADDR, 8'hC3, 32, 144, 480, 1'b1);
        check(fields() == 8'hC3, "R2 R3 R4 high edges", fields(), 8'hC3);

        // R2 R3 R4: one cycle outside each edge is a fault
        write_w(1'b0, MY_ADDR, 8'h0F, 5, ONE_W, TXN_W, 1'b0);
        check(fields() == 8'hC3, "R2 zero too short", fields(), 8'hC3);
        write_w(1'b0, MY_ADDR, 8'h0F, 33, ONE_W, TXN_W, 1'b0);
        check(fields() == 8'hC3, "R2 zero too long", fields(), 8'hC3);
        write_w(1'b0, MY_ADDR, 8'hF0, ZERO_W, 95, TXN_W, 1'b0);
        check(fields() == 8'hC3, "R3 one too short", fields(), 8'hC3);
        write_w(1'b0, MY_ADDR, 8'hF0, ZERO_W, 145, TXN_W, 1'b0);
        check(fields() == 8'hC3, "R3 one too long", fields(), 8'hC3);
        write_w(1'b0, MY_ADDR, 8'h11, ZERO_W, ONE_W, 481, 1'b0);
        check(fields() == 8'hC3, "R4 delimiter too long", fields(), 8'hC3);

        // R11: delimiter mid-frame restarts
        send_hdr(1'b0, MY_ADDR, 1'b0);
        for (int i = 0; i < 3; i++) pulse(ONE_W);
        write_frame(1'b0, MY_ADDR, 8'h26);
        check(fields() == 8'h26, "R11 restart", fields(), 8'h26);

        // R12: trailing bits after a completed write
        for (int i = 0; i < 8; i++) pulse(i[0] ? ONE_W : ZERO_W);
        check(fields() == 8'h26, "R12 trailing ignored", fields(), 8'h26);

        // R9: read again with a different pattern
        read_frame(1'b0, MY_ADDR, "R9 readback second pattern");

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule